// File: doc/BRIEF.md
# Key-Protected Clock Divider Bank

This block derives six slower clocks from one fast source clock using integer dividers. Each channel has an 8-bit divisor and an enable bit that is active low. Software configures the bank through a small 32-bit word-addressed register port. Reads return data in the same cycle. Writes take effect on the rising clock edge.

Divisor writes are ignored unless the key register holds the unlock value. A written divisor first goes to a staging register. The running divider picks it up only after a rising edge on that channel's load bit, and only at the end of the output period in progress, so no short pulse appears on the output. An input from the upstream PLL that reports lock stops every output while lock is low.

The outputs are registered in the source clock domain. They are meant to drive clock-enable or root-clock logic further downstream.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, the control word (address 0) reads 0x0003F000, both divisor words (addresses 4 and 5) read 0, the key word (address 2) reads 0, and all outputs are low.
- R2: A divisor word write is stored only while the key word (address 2) holds 0x0000EA68. A write made while that value is absent is dropped, and readback keeps returning the previous value.
- R3: Writing 0 to the key word locks the bank again. Divisor writes made after that are dropped.
- R4: Address 4 holds the channel 0, 1 and 2 divisors in bits [23:16], [15:8] and [7:0]. Address 5 holds the channel 3, 4 and 5 divisors in the same byte positions.
- R5: Control bits [17:12] are the channel disables, with channel 0 at bit 12. A 1 holds that channel's output low, and a 0 lets it run.
- R6: A staged divisor reaches a channel's divider only after a 0-to-1 change of that channel's load bit. Load bits sit at control bits [5:0], with channel 0 at bit 0. Without that change, the channel keeps its old divisor.
- R7: A loaded divisor takes effect only at the end of the output period in progress. That period finishes at its old length.
- R8: A divisor of 0 divides by 256, giving 128 cycles high and 128 cycles low.
- R9: An even divisor N gives N/2 cycles high and N/2 cycles low. An odd divisor N gives (N-1)/2 cycles high and (N+1)/2 cycles low.
- R10: A divisor of 1 behaves as a divisor of 2.
- R11: While the lock input is 0, all outputs are low. The status word (address 1) shows the lock input at bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pll_locked | input | 1 | Lock indication from the upstream PLL |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, same-cycle |
| div_clk_o | output | 6 | Divided clock outputs, one bit per channel |

## Verification
- **Readback:** the new value is visible in the cycle after the edge that accepted a write.
- **Load path:** a load-bit write is captured at one edge and its rising edge is detected at the next. The divider then waits for the end of its current period.
- **Gating:** a disable bit or a drop in lock forces the output low one edge after the register or input changes.
- **Sampling:** the bench drives inputs and samples outputs on the falling edge. It never checks an output in the cycle an edge is updating it. It measures high and low phase lengths between observed output transitions rather than at fixed cycle offsets, so the period-boundary delay does not shift the expected values.

// File: rtl/clkdiv_pkg.sv
// Shared constants for the divider bank: register word addresses,
// field positions and the unlock key. Assumes three divisor byte lanes
// per 32-bit word.
package clkdiv_pkg;
    localparam int ADR_CTRL = 0;
    localparam int ADR_STAT = 1;
    localparam int ADR_KEY  = 2;
    localparam int ADR_DIV0 = 4;
    localparam int LD_LSB   = 0;
    localparam int ENB_LSB  = 12;
    localparam int LOCK_BIT = 12;
    localparam int LANES    = 3;
    localparam logic [31:0] UNLOCK_KEY = 32'h0000_EA68;
endpackage

// File: rtl/clkdiv_regs.sv
// Register file of the divider bank: control word (load bits and
// active-low enables), key word, staged divisors and readback.
// Assumes DIV_W * LANES <= DATA_W and a synchronous active-low reset.
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    pll_locked,
    output logic [NUM_CH-1:0]       enb_n,
    output logic [NUM_CH*DIV_W-1:0] stage_div,
    output logic [NUM_CH-1:0]       ld_rise,
    output logic                    key_open
);
    logic [DATA_W-1:0] key_q;
    logic [NUM_CH-1:0] enb_q;
    logic [NUM_CH-1:0] ld_q;
    logic [NUM_CH-1:0] ld_prev_q;
    logic [NUM_CH-1:0][DIV_W-1:0] stage_q;
    logic wr_ctrl;
    logic wr_key;

    assign wr_ctrl  = wr_en && (addr == ADDR_W'(ADR_CTRL));
    assign wr_key   = wr_en && (addr == ADDR_W'(ADR_KEY));
    assign key_open = (key_q == DATA_W'(UNLOCK_KEY));
    assign enb_n    = enb_q;
    assign ld_rise  = ld_q & ~ld_prev_q;

    // Control word: disables reset to 1 (outputs off), load bits to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enb_q <= '1;
            ld_q  <= '0;
        end else if (wr_ctrl) begin
            enb_q <= wr_data[ENB_LSB +: NUM_CH];
            ld_q  <= wr_data[LD_LSB +: NUM_CH];
        end
    end

    // Previous load bits, used to find their 0-to-1 changes.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_prev_q <= '0;
        else        ld_prev_q <= ld_q;
    end

    // Key word: any write replaces it; only the unlock value opens the bank.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (wr_key) key_q <= wr_data;
    end

    // Staged divisors: written per byte lane, only while the key is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_en && key_open) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(ADR_DIV0 + i / LANES))
                    stage_q[i] <= wr_data[(LANES - 1 - i % LANES) * DIV_W +: DIV_W];
            end
        end
    end

    // Flatten staged divisors for the channel instances.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            stage_div[i*DIV_W +: DIV_W] = stage_q[i];
    end

    // Same-cycle readback multiplexer; unused addresses read as zero.
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(ADR_CTRL)) begin
            rd_data[ENB_LSB +: NUM_CH] = enb_q;
            rd_data[LD_LSB +: NUM_CH]  = ld_q;
        end
        if (addr == ADDR_W'(ADR_STAT))
            rd_data[LOCK_BIT] = pll_locked;
        if (addr == ADDR_W'(ADR_KEY))
            rd_data = key_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(ADR_DIV0 + i / LANES))
                rd_data[(LANES - 1 - i % LANES) * DIV_W +: DIV_W] = stage_q[i];
        end
    end
endmodule

// File: rtl/clkdiv_chan.sv
// One integer divider channel. The output is high for floor(N/2) source
// cycles and low for the rest, where N is the effective divisor
// (0 -> 2**DIV_W, 1 -> 2). A pending load is applied only at a period
// boundary or while the channel is stopped. Assumes run is synchronous to clk.
module clkdiv_chan #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load_req,
    input  logic [DIV_W-1:0] stage,
    output logic             clk_o
);
    localparam int EFF_W = DIV_W + 1;

    logic [DIV_W-1:0] act_q;
    logic [DIV_W-1:0] cnt_q;
    logic             pend_q;
    logic             out_q;
    logic [DIV_W-1:0] sel;
    logic [DIV_W-1:0] sel_last;
    logic [DIV_W-1:0] act_last;
    logic [DIV_W-1:0] act_half;
    logic [DIV_W-1:0] cnt_inc;
    logic             boundary;

    // Effective divide ratio for a programmed divisor value.
    function automatic logic [EFF_W-1:0] eff(input logic [DIV_W-1:0] v);
        if (v == '0)
            return EFF_W'(1) << DIV_W;
        else if (v == DIV_W'(1))
            return EFF_W'(2);
        else
            return {1'b0, v};
    endfunction

    assign sel      = pend_q ? stage : act_q;
    assign sel_last = DIV_W'(eff(sel) - EFF_W'(1));
    assign act_last = DIV_W'(eff(act_q) - EFF_W'(1));
    assign act_half = DIV_W'(eff(act_q) >> 1);
    assign cnt_inc  = cnt_q + DIV_W'(1);
    assign boundary = (cnt_q >= act_last);
    assign clk_o    = out_q;

    // Counter, active divisor, pending-load flag and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            cnt_q  <= '1;
            pend_q <= 1'b0;
            out_q  <= 1'b0;
        end else if (!run) begin
            act_q  <= sel;
            cnt_q  <= sel_last;
            pend_q <= load_req;
            out_q  <= 1'b0;
        end else if (boundary) begin
            act_q  <= sel;
            cnt_q  <= '0;
            pend_q <= load_req;
            out_q  <= 1'b1;
        end else begin
            cnt_q  <= cnt_inc;
            pend_q <= pend_q | load_req;
            out_q  <= (cnt_inc < act_half);
        end
    end
endmodule

// File: rtl/clkdiv_bank.sv
// Top of the key-protected divider bank: register file plus one divider
// per channel. A channel runs only while its disable bit is 0 and the
// upstream PLL reports lock. Assumes pll_locked is synchronous to clk.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_locked,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] div_clk_o
);
    logic [NUM_CH-1:0]       enb_n;
    logic [NUM_CH*DIV_W-1:0] stage_div;
    logic [NUM_CH-1:0]       ld_rise;
    logic                    key_open;

    clkdiv_regs #(
        .NUM_CH(NUM_CH), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .pll_locked(pll_locked),
        .enb_n     (enb_n),
        .stage_div (stage_div),
        .ld_rise   (ld_rise),
        .key_open  (key_open)
    );

    // One divider per channel, gated by its disable bit and PLL lock.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        clkdiv_chan #(.DIV_W(DIV_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (~enb_n[g] & pll_locked),
            .load_req(ld_rise[g]),
            .stage   (stage_div[g*DIV_W +: DIV_W]),
            .clk_o   (div_clk_o[g])
        );
    end
endmodule

// File: rtl/clkdiv_bank_chk.sv
// Assertion checker for clkdiv_bank, attached with bind. Covers output
// gating, key protection and re-locking.
module clkdiv_bank_chk
    import clkdiv_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pll_locked,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [DATA_W-1:0]       wr_data,
    input logic [NUM_CH-1:0]       div_clk_o,
    input logic [NUM_CH-1:0]       enb_n,
    input logic [NUM_CH*DIV_W-1:0] stage_div,
    input logic                    key_open
);
    // R11: no lock -> every output low after the next edge.
    p_lock_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> (div_clk_o == '0));

    // R2: staged divisors cannot change while the key is closed.
    p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !key_open |=> $stable(stage_div));

    // R2: writing the unlock value opens the bank.
    p_key_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADR_KEY) && wr_data == DATA_W'(UNLOCK_KEY)) |=> key_open);

    // R3: writing zero to the key closes the bank.
    p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADR_KEY) && wr_data == '0) |=> !key_open);

    // R5: a set disable bit forces that output low.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_enb
        p_enb_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            enb_n[g] |=> !div_clk_o[g]);
    end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .NUM_CH(NUM_CH), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_locked(pll_locked),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .div_clk_o (div_clk_o),
    .enb_n     (enb_n),
    .stage_div (stage_div),
    .key_open  (key_open)
);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pll_locked = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [5:0]  div_clk_o;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    clkdiv_bank i_clkdiv_bank (
        .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .div_clk_o(div_clk_o)
    );

    always #2 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rd_data;
    endtask

    // Measures one full high and low phase of a channel, sampled on falling edges.
    task automatic measure(input int ch, output int hi, output int lo);
        int n = 0;
        hi = 0; lo = 0;
        @(negedge clk);
        while (div_clk_o[ch] == 1'b1 && n < 2000) begin @(negedge clk); n++; end
        while (div_clk_o[ch] == 1'b0 && n < 2000) begin @(negedge clk); n++; end
        while (div_clk_o[ch] == 1'b1 && n < 4000) begin @(negedge clk); hi++; n++; end
        while (div_clk_o[ch] == 1'b0 && n < 4000) begin @(negedge clk); lo++; n++; end
    endtask

    task automatic expect_period(input string req, input int ch, input int ehi, input int elo);
        int hi, lo;
        measure(ch, hi, lo);
        chk(req, hi, ehi);
        chk(req, lo, elo);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); chk("R1 ctrl", d, 32'h0003_F000);
        rd(3'd4, d); chk("R1 div0", d, 32'h0);
        rd(3'd5, d); chk("R1 div1", d, 32'h0);
        rd(3'd2, d); chk("R1 key", d, 32'h0);
        chk("R1 outputs", {26'd0, div_clk_o}, 32'h0);
    endtask

    task automatic t_locked_write();
        logic [31:0] d;
        wr(3'd4, 32'h0004_0608);
        rd(3'd4, d); chk("R2 locked write dropped", d, 32'h0);
    endtask

    task automatic t_unlock();
        logic [31:0] d;
        wr(3'd2, 32'h0000_EA68);
        rd(3'd2, d); chk("R2 key readback", d, 32'h0000_EA68);
        wr(3'd4, 32'h0004_0608);
        rd(3'd4, d); chk("R2 R4 div word A", d, 32'h0004_0608);
        wr(3'd5, 32'h0003_0102);
        rd(3'd5, d); chk("R4 div word B", d, 32'h0003_0102);
    endtask

    task automatic t_relock();
        logic [31:0] d;
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h00FF_FFFF);
        rd(3'd4, d); chk("R3 relocked write dropped", d, 32'h0004_0608);
    endtask

    task automatic t_ch0_load();
        int n = 0;
        // Enable channel 0 only; it still runs the reset divisor (0 -> 256).
        wr(3'd0, 32'h0003_E000);
        expect_period("R8 R6 div 256 before load", 0, 128, 128);
        // Measurement ends right at a rising output: load now.
        wr(3'd0, 32'h0003_E001);
        wr(3'd0, 32'h0003_E000);
        while (div_clk_o[0] == 1'b1 && n < 1000) begin @(negedge clk); n++; end
        checks++;
        if (n < 100) begin
            errors++;
            $display("FAIL R7 old period cut: actual %0d expected >= 100", n);
        end
        expect_period("R6 R9 div 4 after load", 0, 2, 2);
    endtask

    task automatic t_all_load();
        wr(3'd0, 32'h0000_0000);
        wr(3'd0, 32'h0000_003E);
        wr(3'd0, 32'h0000_0000);
        expect_period("R4 R9 ch1 div 6", 1, 3, 3);
        expect_period("R4 R9 ch2 div 8", 2, 4, 4);
        expect_period("R4 R9 ch3 odd div 3", 3, 1, 2);
        expect_period("R10 ch4 div 1", 4, 1, 1);
        expect_period("R4 ch5 div 2", 5, 1, 1);
    endtask

    task automatic t_no_load();
        wr(3'd2, 32'h0000_EA68);
        wr(3'd4, 32'h0004_0A08);
        expect_period("R6 ch1 unchanged without load", 1, 3, 3);
        wr(3'd0, 32'h0000_0002);
        wr(3'd0, 32'h0000_0000);
        expect_period("R6 ch1 div 10 after load", 1, 5, 5);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        bit seen = 0;
        wr(3'd0, 32'h0000_4000);
        rd(3'd0, d); chk("R5 ctrl readback", d, 32'h0000_4000);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_clk_o[2]) seen = 1;
        end
        chk("R5 ch2 held low", {31'd0, seen}, 32'h0);
        expect_period("R5 ch0 still running", 0, 2, 2);
    endtask

    task automatic t_pll_lock();
        logic [31:0] d;
        bit seen = 0;
        @(negedge clk); pll_locked = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_clk_o != 6'd0) seen = 1;
        end
        chk("R11 outputs low without lock", {31'd0, seen}, 32'h0);
        rd(3'd1, d); chk("R11 status unlocked", d, 32'h0);
        @(negedge clk); pll_locked = 1'b1;
        rd(3'd1, d); chk("R11 status locked", d, 32'h0000_1000);
        expect_period("R11 ch0 resumes", 0, 2, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_write();
        t_unlock();
        t_relock();
        t_ch0_load();
        t_all_load();
        t_no_load();
        t_disable();
        t_pll_lock();
        finish_run();
    end
endmodule